// File: doc/BRIEF.md
# Timer-Side Capture/Compare Unit

This unit sits next to a free-running 16-bit timer. It reads the timer's count and the timer's increment enable, and it can send back a single clear request. It holds one 16-bit capture/compare value. Software loads that value one byte at a time through byte strobes. The unit works in one of four modes.

- **Off:** the unit does nothing.
- **Capture:** the timer count is latched when the selected edge pattern appears on an asynchronous input pin.
- **Compare:** a one-cycle event pulse is produced when the timer reaches the stored value.
- **Period:** this is compare mode with one addition. The match also clears the timer, so the stored value becomes the timer's period. The timer then counts 0, 1, …, P, 0, … and never passes through its own rollover.

Every capture and every compare match sets a sticky interrupt flag owned by the unit. Software clears that flag with a strobe.

Top module: `ccu_top`

## Requirements
- R1: After reset, ccr_value is 0, and irq_flag, cmp_evt and tmr_clear are all 0.
- R2: wr_be[0] writes wr_data into ccr_value[7:0], and wr_be[1] writes it into ccr_value[15:8]. The new value is visible after the next rising clock edge.
- R3: With mode=01 (capture), a selected pin event copies tmr_count into ccr_value. cap_sel picks the event: 00 every falling edge, 01 every rising edge, 10 every 4th rising edge, 11 every 16th rising edge. The pin passes through a two-flop synchronizer, so the capture lands on the third rising clock edge after the pin changes.
- R4: The rising-edge prescale count restarts from zero whenever cap_sel changes or the mode leaves capture.
- R5: In capture mode a byte write still overwrites the stored value. When a capture and a write fall in the same cycle, the capture wins.
- R6: With mode=10 or 11, a cycle with tmr_tick=1 and tmr_count equal to ccr_value produces cmp_evt=1 for exactly the following cycle. A held count (tmr_tick=0) produces no event.
- R7: With mode=11 (period), tmr_clear is high in the same cycle as the match, so the timer counts 0 up to ccr_value and then returns to 0. With any other mode, tmr_clear stays 0.
- R8: irq_flag is set by each capture or compare event. It stays set until flag_clr is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R9: A period clear returns the timer to 0 without passing through FFFFh, so the timer's own rollover flag stays clear while irq_flag is set. Compare mode does not clear the timer, so the timer rolls over normally.
- R10: With mode=00, pin edges and timer matches change neither ccr_value nor irq_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_count | input | 16 | Current timer count |
| tmr_tick | input | 1 | Timer advances at the next edge |
| tmr_clear | output | 1 | Request to load 0 into the timer instead of incrementing |
| mode | input | 2 | 00 off, 01 capture, 10 compare, 11 period |
| cap_sel | input | 2 | Capture event select (see R3) |
| cap_pin | input | 1 | Asynchronous capture input |
| wr_be | input | 2 | Byte write strobes, bit 0 low byte |
| wr_data | input | 8 | Byte write data |
| flag_clr | input | 1 | Clears irq_flag |
| ccr_value | output | 16 | Stored capture/compare value |
| irq_flag | output | 1 | Sticky event flag |
| cmp_evt | output | 1 | One-cycle compare event pulse |

## Verification
Each result has its own latency after its stimulus:

- **tmr_clear:** combinational with the matching count, so it is sampled 1 ns after the inputs change on the falling edge.
- **cmp_evt, irq_flag and byte writes:** registered once, so they are sampled on the falling edge after one rising edge.
- **Captures:** these need three rising edges (two synchronizer stages, then the load). The bench checks that the value has not moved after two edges and has moved after the third.

The period sequence is checked against a timer model in the bench, and the model is advanced by the unit's own clear request.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

  localparam int PRE_W = 4;

  typedef enum logic [1:0] {
    CCU_OFF     = 2'b00,
    CCU_CAPTURE = 2'b01,
    CCU_COMPARE = 2'b10,
    CCU_PERIOD  = 2'b11
  } ccu_mode_e;

  typedef enum logic [1:0] {
    SEL_FALL    = 2'b00,
    SEL_RISE    = 2'b01,
    SEL_RISE4   = 2'b10,
    SEL_RISE16  = 2'b11
  } cap_sel_e;

  // Index of the rising edge (counted from 0) that fires a capture.
  function automatic logic [PRE_W-1:0] last_edge_index(input logic [1:0] sel);
    case (sel)
      SEL_RISE4:  return PRE_W'(3);
      SEL_RISE16: return PRE_W'(15);
      default:    return '0;
    endcase
  endfunction

  function automatic logic is_capture(input logic [1:0] m);
    return m == CCU_CAPTURE;
  endfunction

  function automatic logic is_compare(input logic [1:0] m);
    return (m == CCU_COMPARE) || (m == CCU_PERIOD);
  endfunction

  function automatic logic is_period(input logic [1:0] m);
    return m == CCU_PERIOD;
  endfunction

endpackage

// File: rtl/ccu_capture_edge.sv
module ccu_capture_edge
  import ccu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic       enable,
  input  logic [1:0] sel,
  output logic       cap_fire
);

  logic [SYNC_STAGES:0] sh;
  logic                 rise, fall, sel_same;
  logic [1:0]           sel_q;
  logic [PRE_W-1:0]     edge_cnt;
  logic [PRE_W-1:0]     target;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_STAGES-1:0], pin};
  end

  assign rise     = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
  assign fall     = ~sh[SYNC_STAGES-1] & sh[SYNC_STAGES];
  assign sel_same = (sel == sel_q);
  assign target   = last_edge_index(sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= SEL_FALL;
      edge_cnt <= '0;
    end else begin
      sel_q <= sel;
      if (!enable || !sel_same)
        edge_cnt <= '0;
      else if (rise && sel != SEL_FALL)
        edge_cnt <= (edge_cnt == target) ? '0 : edge_cnt + 1'b1;
    end
  end

  always_comb begin
    cap_fire = 1'b0;
    if (enable && sel_same) begin
      if (sel == SEL_FALL) cap_fire = fall;
      else                 cap_fire = rise && (edge_cnt == target);
    end
  end

endmodule

// File: rtl/ccu_compare.sv
module ccu_compare
  import ccu_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          tick,
  input  logic [TW-1:0] count,
  input  logic [TW-1:0] ccr,
  output logic          match,
  output logic          clr_req,
  output logic          evt_q
);

  assign match   = is_compare(mode) && tick && (count == ccr);
  assign clr_req = match && is_period(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= match;
  end

endmodule

// File: rtl/ccu_store.sv
module ccu_store #(
  parameter int TW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW/8-1:0]  wr_be,
  input  logic [7:0]       wr_data,
  input  logic             cap_fire,
  input  logic [TW-1:0]    cap_value,
  input  logic             flag_set,
  input  logic             flag_clr,
  output logic [TW-1:0]    ccr,
  output logic             flag
);

  localparam int NB = TW / 8;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ccr[b*8 +: 8] <= '0;
      else if (cap_fire)  ccr[b*8 +: 8] <= cap_value[b*8 +: 8];
      else if (wr_be[b])  ccr[b*8 +: 8] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (flag_set) flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

endmodule

// File: rtl/ccu_top.sv
module ccu_top
  import ccu_pkg::*;
#(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TW-1:0]   tmr_count,
  input  logic            tmr_tick,
  output logic            tmr_clear,
  input  logic [1:0]      mode,
  input  logic [1:0]      cap_sel,
  input  logic            cap_pin,
  input  logic [TW/8-1:0] wr_be,
  input  logic [7:0]      wr_data,
  input  logic            flag_clr,
  output logic [TW-1:0]   ccr_value,
  output logic            irq_flag,
  output logic            cmp_evt
);

  logic cap_fire;
  logic cmp_match;

  ccu_capture_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (cap_pin),
    .enable   (is_capture(mode)),
    .sel      (cap_sel),
    .cap_fire (cap_fire)
  );

  ccu_compare #(.TW(TW)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .tick    (tmr_tick),
    .count   (tmr_count),
    .ccr     (ccr_value),
    .match   (cmp_match),
    .clr_req (tmr_clear),
    .evt_q   (cmp_evt)
  );

  ccu_store #(.TW(TW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_be     (wr_be),
    .wr_data   (wr_data),
    .cap_fire  (cap_fire),
    .cap_value (tmr_count),
    .flag_set  (cap_fire | cmp_match),
    .flag_clr  (flag_clr),
    .ccr       (ccr_value),
    .flag      (irq_flag)
  );

endmodule

// File: rtl/ccu_checker.sv
module ccu_checker #(
  parameter int TW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [TW-1:0]   tmr_count,
  input logic            tmr_tick,
  input logic            tmr_clear,
  input logic [1:0]      mode,
  input logic [TW/8-1:0] wr_be,
  input logic [7:0]      wr_data,
  input logic            flag_clr,
  input logic [TW-1:0]   ccr_value,
  input logic            irq_flag,
  input logic            cmp_evt,
  input logic            cap_fire,
  input logic            cmp_match
);

  assert_write_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_be[0] && !cap_fire) |=> ccr_value[7:0] == $past(wr_data));

  assert_capture_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> ccr_value == $past(tmr_count));

  assert_evt_needs_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |-> ($past(tmr_tick) && $past(mode[1])));

  assert_clear_only_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_clear |-> (mode == 2'b11));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_clr) |=> irq_flag);

  assert_flag_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(cap_fire || cmp_match));

  assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> (!cap_fire && !cmp_match));

endmodule

bind ccu_top ccu_checker #(.TW(TW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tmr_count (tmr_count),
  .tmr_tick  (tmr_tick),
  .tmr_clear (tmr_clear),
  .mode      (mode),
  .wr_be     (wr_be),
  .wr_data   (wr_data),
  .flag_clr  (flag_clr),
  .ccr_value (ccr_value),
  .irq_flag  (irq_flag),
  .cmp_evt   (cmp_evt),
  .cap_fire  (cap_fire),
  .cmp_match (cmp_match)
);

// File: tb/sim_ccu_top.sv
module sim_ccu_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tmr_count;
  logic        tmr_tick;
  logic        tmr_clear;
  logic [1:0]  mode = 2'b00;
  logic [1:0]  cap_sel = 2'b01;
  logic        cap_pin = 1'b0;
  logic [1:0]  wr_be = 2'b00;
  logic [7:0]  wr_data = 8'h00;
  logic        flag_clr = 1'b0;
  logic [15:0] ccr_value;
  logic        irq_flag;
  logic        cmp_evt;

  logic [15:0] drv_count = 16'h0000;
  logic        drv_tick = 1'b0;
  logic        use_model = 1'b0;
  logic        mdl_load = 1'b0;
  logic        mdl_run = 1'b0;
  logic [15:0] mdl_seed = 16'h0000;
  logic [15:0] mdl_count = 16'h0000;
  logic        mdl_ovf = 1'b0;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  assign tmr_count = use_model ? mdl_count : drv_count;
  assign tmr_tick  = use_model ? mdl_run   : drv_tick;

  // Timer model: clears on request, otherwise increments and flags its own rollover.
  always @(posedge clk) begin
    if (mdl_load) begin
      mdl_count <= mdl_seed;
      mdl_ovf   <= 1'b0;
    end else if (use_model && mdl_run) begin
      if (tmr_clear) mdl_count <= 16'h0000;
      else begin
        mdl_count <= mdl_count + 16'h0001;
        if (mdl_count == 16'hFFFF) mdl_ovf <= 1'b1;
      end
    end
  end

  ccu_top u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmr_count (tmr_count),
    .tmr_tick  (tmr_tick),
    .tmr_clear (tmr_clear),
    .mode      (mode),
    .cap_sel   (cap_sel),
    .cap_pin   (cap_pin),
    .wr_be     (wr_be),
    .wr_data   (wr_data),
    .flag_clr  (flag_clr),
    .ccr_value (ccr_value),
    .irq_flag  (irq_flag),
    .cmp_evt   (cmp_evt)
  );

  typedef struct packed {
    logic [1:0]  md;
    logic [15:0] ccr;
    logic [15:0] cnt;
    logic        tick;
    logic        evt;
    logic        clr;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'b10, 16'h1234, 16'h1234, 1'b1, 1'b1, 1'b0},
    '{2'b10, 16'h1234, 16'h1235, 1'b1, 1'b0, 1'b0},
    '{2'b10, 16'h00FF, 16'h00FF, 1'b0, 1'b0, 1'b0},
    '{2'b11, 16'h0040, 16'h0040, 1'b1, 1'b1, 1'b1},
    '{2'b11, 16'h0040, 16'h0041, 1'b1, 1'b0, 1'b0},
    '{2'b00, 16'h5555, 16'h5555, 1'b1, 1'b0, 1'b0},
    '{2'b01, 16'h0777, 16'h0777, 1'b1, 1'b0, 1'b0},
    '{2'b11, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 1'b1},
    '{2'b10, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic write_ccr(input logic [15:0] v);
    @(negedge clk); wr_be = 2'b01; wr_data = v[7:0];
    @(negedge clk); wr_be = 2'b10; wr_data = v[15:8];
    @(negedge clk); wr_be = 2'b00;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  // Drive the pin, then wait until a capture from it is due (three rising edges).
  task automatic pin_to(input logic v);
    @(negedge clk); cap_pin = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rise_fall(input logic [15:0] cnt_during);
    drv_count = cnt_during;
    pin_to(1'b1);
    pin_to(1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "ccr", {16'h0, ccr_value}, 32'h0);
    chk("R1", "flag", {31'h0, irq_flag}, 32'h0);
    chk("R1", "evt", {31'h0, cmp_evt}, 32'h0);
    chk("R1", "clr", {31'h0, tmr_clear}, 32'h0);

    // R2 byte writes
    @(negedge clk); wr_be = 2'b01; wr_data = 8'h34;
    @(negedge clk); wr_be = 2'b00;
    chk("R2", "low byte", {16'h0, ccr_value}, 32'h0034);
    wr_be = 2'b10; wr_data = 8'h12;
    @(negedge clk); wr_be = 2'b00;
    chk("R2", "high byte", {16'h0, ccr_value}, 32'h1234);

    // R6 R7 R8 R10 vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode = VECS[i].md; drv_tick = 1'b0; drv_count = 16'hA5A5;
      write_ccr(VECS[i].ccr);
      clear_flag();
      drv_count = VECS[i].cnt; drv_tick = VECS[i].tick;
      #1;
      chk("R7", "tmr_clear same cycle", {31'h0, tmr_clear}, {31'h0, VECS[i].clr});
      @(negedge clk);
      chk("R6", "cmp_evt", {31'h0, cmp_evt}, {31'h0, VECS[i].evt});
      chk("R8", "flag from match", {31'h0, irq_flag}, {31'h0, VECS[i].evt});
      drv_tick = 1'b0;
      @(negedge clk);
      chk("R6", "single pulse", {31'h0, cmp_evt}, 32'h0);
    end

    // R8 set and clear in same cycle: set wins; then clear alone
    mode = 2'b10; write_ccr(16'h0020); clear_flag();
    drv_count = 16'h0020; drv_tick = 1'b1; flag_clr = 1'b1;
    @(negedge clk); drv_tick = 1'b0; flag_clr = 1'b0;
    chk("R8", "set beats clear", {31'h0, irq_flag}, 32'h1);
    @(negedge clk);
    chk("R8", "sticky", {31'h0, irq_flag}, 32'h1);
    clear_flag();
    chk("R8", "cleared", {31'h0, irq_flag}, 32'h0);

    // R3 capture on rising edge, with latency check
    mode = 2'b01; cap_sel = 2'b01; write_ccr(16'h0000); clear_flag();
    drv_count = 16'hBEEF;
    @(negedge clk); cap_pin = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R3", "not before third edge", {16'h0, ccr_value}, 32'h0000);
    @(negedge clk);
    chk("R3", "rising capture", {16'h0, ccr_value}, 32'hBEEF);
    chk("R8", "flag from capture", {31'h0, irq_flag}, 32'h1);
    drv_count = 16'h1111; pin_to(1'b0);
    chk("R3", "falling ignored in rising mode", {16'h0, ccr_value}, 32'hBEEF);

    // R3 falling mode
    cap_sel = 2'b00; @(negedge clk);
    drv_count = 16'h2222; pin_to(1'b1);
    chk("R3", "rising ignored in falling mode", {16'h0, ccr_value}, 32'hBEEF);
    drv_count = 16'h3333; pin_to(1'b0);
    chk("R3", "falling capture", {16'h0, ccr_value}, 32'h3333);

    // R3 every 4th rising edge
    cap_sel = 2'b10; @(negedge clk);
    for (int k = 1; k <= 3; k++) rise_fall(16'h0100 + 16'(k));
    chk("R3", "div4 before 4th", {16'h0, ccr_value}, 32'h3333);
    rise_fall(16'h0104);
    chk("R3", "div4 on 4th", {16'h0, ccr_value}, 32'h0104);

    // R3 every 16th rising edge
    cap_sel = 2'b11; @(negedge clk);
    for (int k = 1; k <= 15; k++) rise_fall(16'h0200 + 16'(k));
    chk("R3", "div16 before 16th", {16'h0, ccr_value}, 32'h0104);
    rise_fall(16'h0210);
    chk("R3", "div16 on 16th", {16'h0, ccr_value}, 32'h0210);

    // R4 prescale restart on select change
    for (int k = 1; k <= 3; k++) rise_fall(16'h0300 + 16'(k));
    cap_sel = 2'b10; @(negedge clk); @(negedge clk);
    for (int k = 1; k <= 3; k++) rise_fall(16'h0400 + 16'(k));
    chk("R4", "restart after select change", {16'h0, ccr_value}, 32'h0210);
    rise_fall(16'h0404);
    chk("R4", "fires on 4th after change", {16'h0, ccr_value}, 32'h0404);

    // R4 prescale restart on leaving capture mode
    for (int k = 1; k <= 2; k++) rise_fall(16'h0500 + 16'(k));
    mode = 2'b00; @(negedge clk); @(negedge clk);
    mode = 2'b01; @(negedge clk);
    for (int k = 1; k <= 3; k++) rise_fall(16'h0600 + 16'(k));
    chk("R4", "restart after mode exit", {16'h0, ccr_value}, 32'h0404);
    rise_fall(16'h0604);
    chk("R4", "fires on 4th after re-entry", {16'h0, ccr_value}, 32'h0604);

    // R5 write works in capture mode; capture beats a same-cycle write
    write_ccr(16'h4242);
    chk("R5", "write in capture mode", {16'h0, ccr_value}, 32'h4242);
    cap_sel = 2'b01; @(negedge clk);
    drv_count = 16'hC0DE;
    @(negedge clk); cap_pin = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_be = 2'b11; wr_data = 8'h99;
    @(negedge clk); wr_be = 2'b00;
    chk("R5", "capture beats write", {16'h0, ccr_value}, 32'hC0DE);
    pin_to(1'b0);

    // R10 off mode: edges and matches have no effect
    mode = 2'b00; clear_flag();
    drv_count = 16'h7777; pin_to(1'b1); pin_to(1'b0);
    drv_count = ccr_value; drv_tick = 1'b1;
    @(negedge clk); drv_tick = 1'b0;
    chk("R10", "ccr unchanged", {16'h0, ccr_value}, 32'hC0DE);
    chk("R10", "flag unchanged", {31'h0, irq_flag}, 32'h0);
    chk("R10", "no event", {31'h0, cmp_evt}, 32'h0);

    // R7 R9 period sequence against timer model
    mode = 2'b11; write_ccr(16'h0005); clear_flag();
    @(negedge clk); mdl_seed = 16'h0000; mdl_load = 1'b1;
    @(negedge clk); mdl_load = 1'b0; use_model = 1'b1; mdl_run = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      chk("R7", "period count", {16'h0, tmr_count}, 32'(k % 6));
    end
    mdl_run = 1'b0;
    @(negedge clk);
    chk("R9", "no timer rollover", {31'h0, mdl_ovf}, 32'h0);
    chk("R9", "unit flag set", {31'h0, irq_flag}, 32'h1);

    // R9 compare mode does not clear: timer rolls over
    use_model = 1'b0; mode = 2'b10; write_ccr(16'h0003);
    @(negedge clk); mdl_seed = 16'hFFFD; mdl_load = 1'b1;
    @(negedge clk); mdl_load = 1'b0; use_model = 1'b1; mdl_run = 1'b1;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      chk("R7", "no clear in compare", {31'h0, tmr_clear}, 32'h0);
    end
    mdl_run = 1'b0;
    @(negedge clk);
    chk("R9", "count passes match", {16'h0, tmr_count}, 32'h0004);
    chk("R9", "timer rollover seen", {31'h0, mdl_ovf}, 32'h1);
    use_model = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule